// File: doc/BRIEF.md
# PHY Discovery and Configuration Sequencer

After each start pulse this block walks every management address of a serial PHY management bus and looks for transceivers that answer with a plausible status word. Up to a fixed number of transceivers are recorded. For each one it works out which abilities to advertise and writes that value when it differs from the value the device holds. It then rebuilds the basic control register from the configuration inputs. Every register access goes through an external management-bus master over a one-request, one-completion handshake. Bit timing on the wire is left to that master.

The configuration inputs are an optional forced advertise word, a forced-media select, and full-duplex and 100 Mb/s selects. The results are a table of PHY addresses, a matching table of advertise words, and a count of PHYs found. The advertise table and an internally learned advertise value survive from one scan to the next and are cleared only by reset. When the board needs an MII transceiver and none answered, the block puts address 1 in the first entry and raises a warning flag.

Top module: `phy_scan_seq`

## Requirements
- R1: A scan reads status register 1 at addresses 1, 2, … 31 and then at address 0, one status read per address, in that order.
- R2: A status word S accepts its PHY when (S & 16'h8301) == 16'h8001, or when S[15] is 0 and S[14:11] is nonzero. Any other PHY is skipped with no further access.
- R3: Accepted PHYs fill table entries 0, 1, 2 … in the order found, and phy_count gives their number. Once SLOTS entries are filled, no further address is probed. A start pulse clears the address entries.
- R4: For each accepted PHY the sequencer reads register 0 and then register 4. If bits 9:5 of the register-4 value are all zero, it reads register 1 again and uses ((S >> 6) & 16'h03E0) | 1 as the read advertise value.
- R5: The advertise value to program is chosen as follows. A nonzero force_adv comes first. Otherwise a nonzero learned value is used, then a nonzero stored entry for the same table slot, and finally the read advertise value, which is also kept as the learned value. The table entry takes the chosen value. Both the entries and the learned value persist across scans until reset.
- R6: Register 4 is written, with the chosen value, only when that value differs from the read advertise value.
- R7: The new control word starts from the register-0 value read. With force_media at 0, bit 12 is set, and bit 9 is also set if bit 12 was 0. With force_media at 1, bit 12 is cleared. Bits 15, 14, 13, 11, 10, 8 and 7 are then cleared. Bit 8 is set from fdx_sel and bit 13 from spd100_sel.
- R8: Register 0 is written only when the new control word differs from the value read. When bit 12 changed, it is written twice, with at least WAIT_CYCLES clocks between the two requests.
- R9: If need_mii is 1 and no PHY was accepted, entry 0 takes address 1 and no_phy_warn rises. The flag clears at the next start.
- R10: scan_done is a one-cycle pulse after the last access of a scan, and busy falls with it. phy_count holds its value until the next start.
- R11: mdio_req is a one-cycle pulse, and no new request is issued before the completion of the previous one.
- R12: After reset, busy, scan_done, mdio_req, no_phy_warn, phy_count and both tables read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a scan when idle |
| force_adv | input | 16 | Advertise value to impose, 0 for none |
| force_media | input | 1 | 1: turn autonegotiation off |
| fdx_sel | input | 1 | Requests full duplex in the control word |
| spd100_sel | input | 1 | Requests 100 Mb/s in the control word |
| need_mii | input | 1 | Board expects an MII transceiver |
| mdio_req | output | 1 | Access request pulse to the bus master |
| mdio_wr | output | 1 | 1: write access, 0: read access |
| mdio_phy | output | 5 | PHY address of the access |
| mdio_reg | output | 5 | Register number of the access |
| mdio_wdata | output | 16 | Write data |
| mdio_done | input | 1 | Completion pulse from the master |
| mdio_rdata | input | 16 | Read data, valid with mdio_done |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | End-of-scan pulse |
| phy_count | output | 3 | Number of PHYs found |
| phy_addrs | output | 20 | Found addresses, entry k at bits 5k+4:5k |
| phy_advs | output | 64 | Advertise values, entry k at bits 16k+15:16k |
| no_phy_warn | output | 1 | Required transceiver missing |

## Verification
The assertions check on every cycle that each request is a single pulse. They also check that any write to register 4 or register 0 carries a value different from the one last read there. Further checks are that the done pulse ends the scan, that the count never passes the table size, that the warning appears only with an empty table, and that the hold timer is never restarted while it is running. The scan order, the validity decision, the advertise precedence across successive scans and the exact control words can be shown only by the bench scenarios. So can the write-twice spacing and the stop on a full table. Each of these scenarios compares the logged bus traffic and the final tables with values worked out by hand.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;
   localparam int REG_W  = 16;
   localparam int ADDR_W = 5;

   localparam logic [ADDR_W-1:0] RA_CTL  = 5'd0;
   localparam logic [ADDR_W-1:0] RA_STAT = 5'd1;
   localparam logic [ADDR_W-1:0] RA_ADV  = 5'd4;

   localparam logic [REG_W-1:0] CTL_AN_EN  = 16'h1000;
   localparam logic [REG_W-1:0] CTL_AN_RST = 16'h0200;
   localparam logic [REG_W-1:0] CTL_FDX    = 16'h0100;
   localparam logic [REG_W-1:0] CTL_SPD    = 16'h2000;
   localparam logic [REG_W-1:0] CTL_WIPE   = 16'hED80;

   typedef enum logic [3:0] {
      ST_IDLE, ST_PROBE, ST_RD_CTL, ST_RD_ADV, ST_RD_CAP, ST_PICK,
      ST_WR_ADV, ST_WR_CTL_A, ST_HOLD, ST_WR_CTL_B, ST_NEXT, ST_FINISH
   } seq_state_t;

   function automatic logic stat_ok(input logic [REG_W-1:0] s);
      return ((s & 16'h8301) == 16'h8001) || (!s[15] && (s[14:11] != 4'd0));
   endfunction

   function automatic logic [REG_W-1:0] cap_to_adv(input logic [REG_W-1:0] s);
      return ((s >> 6) & 16'h03E0) | 16'h0001;
   endfunction
endpackage

// File: rtl/phy_hold_timer.sv
module phy_hold_timer #(
   parameter int CYCLES = 500,
   localparam int CW = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic run
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("phy_hold_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (go)              cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
   end

   assign run = (cnt_q != '0);

   // R8
   go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (cnt_q == '0));
endmodule

// File: rtl/phy_entry_table.sv
module phy_entry_table
   import phy_scan_pkg::*;
#(
   parameter int SLOTS = 4,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    addr_we,
   input  logic                    adv_we,
   input  logic [SLOT_W-1:0]       idx,
   input  logic [ADDR_W-1:0]       addr_in,
   input  logic [REG_W-1:0]        adv_in,
   output logic [REG_W-1:0]        adv_sel,
   output logic [SLOTS*ADDR_W-1:0] addr_flat,
   output logic [SLOTS*REG_W-1:0]  adv_flat
);
   logic [REG_W-1:0] adv_view [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [ADDR_W-1:0] a_q;
      logic [REG_W-1:0]  v_q;
      logic              hit;

      assign hit = (idx == SLOT_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            a_q <= '0;
            v_q <= '0;
         end else begin
            if (clr)                a_q <= '0;
            else if (addr_we && hit) a_q <= addr_in;
            if (adv_we && hit)      v_q <= adv_in;
         end
      end

      assign addr_flat[g*ADDR_W +: ADDR_W] = a_q;
      assign adv_flat[g*REG_W +: REG_W]    = v_q;
      assign adv_view[g]                   = v_q;
   end

   assign adv_sel = adv_view[idx];

   // R3
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (addr_flat == '0));
endmodule

// File: rtl/phy_scan_fsm.sv
module phy_scan_fsm
   import phy_scan_pkg::*;
#(
   parameter int SLOTS = 4,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int CNT_W  = $clog2(SLOTS + 1),
   localparam int PROBES = 1 << ADDR_W,
   localparam int PN_W   = $clog2(PROBES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [REG_W-1:0]  force_adv,
   input  logic              force_media,
   input  logic              fdx_sel,
   input  logic              spd100_sel,
   input  logic              need_mii,
   output logic              mdio_req,
   output logic              mdio_wr,
   output logic [ADDR_W-1:0] mdio_phy,
   output logic [ADDR_W-1:0] mdio_reg,
   output logic [REG_W-1:0]  mdio_wdata,
   input  logic              mdio_done,
   input  logic [REG_W-1:0]  mdio_rdata,
   output logic              tbl_clr,
   output logic              tbl_addr_we,
   output logic              tbl_adv_we,
   output logic [SLOT_W-1:0] tbl_idx,
   output logic [ADDR_W-1:0] tbl_addr,
   output logic [REG_W-1:0]  tbl_adv,
   input  logic [REG_W-1:0]  tbl_adv_stored,
   output logic              tmr_go,
   input  logic              tmr_run,
   output logic              busy,
   output logic              scan_done,
   output logic [CNT_W-1:0]  phy_count,
   output logic              no_phy_warn
);
   if (SLOTS < 1 || SLOTS > PROBES) begin : g_bad_slots
      $error("phy_scan_fsm: SLOTS out of range");
   end

   seq_state_t        st_q, st_d;
   logic              pend_q, step, acc;
   logic [PN_W-1:0]   probe_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [REG_W-1:0]  ctl_q, adv_q, glob_q, to_adv_q, ctl_nq;
   logic              sw_q, warn_q;

   logic [REG_W-1:0]  eff_force, pick_adv, ctl_c;
   logic              pick_store, pick_glob, sw_c, glob_we, warn_set;

   function automatic seq_state_t ctl_route(input logic differ, input logic sw);
      if (!differ) return ST_NEXT;
      return sw ? ST_WR_CTL_A : ST_WR_CTL_B;
   endfunction

   // advertise precedence
   always_comb begin
      eff_force  = (force_adv != '0) ? force_adv : glob_q;
      pick_adv   = adv_q;
      pick_store = 1'b1;
      pick_glob  = 1'b0;
      if (eff_force != '0) begin
         pick_adv = eff_force;
      end else if (tbl_adv_stored != '0) begin
         pick_adv   = tbl_adv_stored;
         pick_store = 1'b0;
      end else begin
         pick_glob = 1'b1;
      end
   end

   // control word rebuild
   always_comb begin
      ctl_c = force_media ? (ctl_q & ~CTL_AN_EN) : (ctl_q | CTL_AN_EN);
      sw_c  = (ctl_c[12] != ctl_q[12]);
      if (!force_media && sw_c) ctl_c = ctl_c | CTL_AN_RST;
      ctl_c = ctl_c & ~CTL_WIPE;
      if (fdx_sel)    ctl_c = ctl_c | CTL_FDX;
      if (spd100_sel) ctl_c = ctl_c | CTL_SPD;
   end

   assign step = pend_q && mdio_done;

   always_comb begin
      st_d        = st_q;
      tbl_clr     = 1'b0;
      tbl_addr_we = 1'b0;
      tbl_adv_we  = 1'b0;
      glob_we     = 1'b0;
      tmr_go      = 1'b0;
      warn_set    = 1'b0;
      unique case (st_q)
         ST_IDLE:     if (start) begin tbl_clr = 1'b1; st_d = ST_PROBE; end
         ST_PROBE:    if (step) st_d = stat_ok(mdio_rdata) ? ST_RD_CTL : ST_NEXT;
         ST_RD_CTL:   if (step) st_d = ST_RD_ADV;
         ST_RD_ADV:   if (step) st_d = (mdio_rdata[9:5] == 5'd0) ? ST_RD_CAP : ST_PICK;
         ST_RD_CAP:   if (step) st_d = ST_PICK;
         ST_PICK: begin
            tbl_addr_we = 1'b1;
            tbl_adv_we  = pick_store;
            glob_we     = pick_glob;
            if (pick_adv != adv_q) st_d = ST_WR_ADV;
            else                   st_d = ctl_route(ctl_c != ctl_q, sw_c);
         end
         ST_WR_ADV:   if (step) st_d = ctl_route(ctl_nq != ctl_q, sw_q);
         ST_WR_CTL_A: if (step) begin tmr_go = 1'b1; st_d = ST_HOLD; end
         ST_HOLD:     if (!tmr_run) st_d = ST_WR_CTL_B;
         ST_WR_CTL_B: if (step) st_d = ST_NEXT;
         ST_NEXT:     st_d = (probe_q == PN_W'(PROBES) || cnt_q == CNT_W'(SLOTS)) ?
                             ST_FINISH : ST_PROBE;
         ST_FINISH: begin
            if (need_mii && cnt_q == '0) begin
               tbl_addr_we = 1'b1;
               warn_set    = 1'b1;
            end
            st_d = ST_IDLE;
         end
         default:     st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         pend_q   <= 1'b0;
         probe_q  <= '0;
         cnt_q    <= '0;
         ctl_q    <= '0;
         adv_q    <= '0;
         glob_q   <= '0;
         to_adv_q <= '0;
         ctl_nq   <= '0;
         sw_q     <= 1'b0;
         warn_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (mdio_req)  pend_q <= 1'b1;
         else if (step) pend_q <= 1'b0;
         if (tbl_clr) begin
            cnt_q   <= '0;
            probe_q <= PN_W'(1);
            warn_q  <= 1'b0;
         end
         if (step && st_q == ST_RD_CTL) ctl_q <= mdio_rdata;
         if (step && st_q == ST_RD_ADV) adv_q <= mdio_rdata;
         if (step && st_q == ST_RD_CAP) adv_q <= cap_to_adv(mdio_rdata);
         if (st_q == ST_PICK) begin
            to_adv_q <= pick_adv;
            ctl_nq   <= ctl_c;
            sw_q     <= sw_c;
            cnt_q    <= cnt_q + CNT_W'(1);
         end
         if (glob_we) glob_q <= pick_adv;
         if (st_q == ST_NEXT && st_d == ST_PROBE) probe_q <= probe_q + PN_W'(1);
         if (warn_set) warn_q <= 1'b1;
      end
   end

   always_comb begin
      acc        = 1'b0;
      mdio_wr    = 1'b0;
      mdio_reg   = RA_STAT;
      mdio_wdata = ctl_nq;
      unique case (st_q)
         ST_PROBE, ST_RD_CAP: acc = 1'b1;
         ST_RD_CTL:   begin acc = 1'b1; mdio_reg = RA_CTL; end
         ST_RD_ADV:   begin acc = 1'b1; mdio_reg = RA_ADV; end
         ST_WR_ADV:   begin acc = 1'b1; mdio_reg = RA_ADV; mdio_wr = 1'b1; mdio_wdata = to_adv_q; end
         ST_WR_CTL_A, ST_WR_CTL_B: begin acc = 1'b1; mdio_reg = RA_CTL; mdio_wr = 1'b1; end
         default: ;
      endcase
   end

   assign mdio_req    = acc && !pend_q;
   assign mdio_phy    = probe_q[ADDR_W-1:0];
   assign tbl_idx     = (st_q == ST_FINISH) ? '0 : cnt_q[SLOT_W-1:0];
   assign tbl_addr    = (st_q == ST_FINISH) ? ADDR_W'(1) : probe_q[ADDR_W-1:0];
   assign tbl_adv     = pick_adv;
   assign busy        = (st_q != ST_IDLE);
   assign scan_done   = (st_q == ST_FINISH);
   assign phy_count   = cnt_q;
   assign no_phy_warn = warn_q;

   // R11
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_req |=> !mdio_req);
   // R6
   adv_wr_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_req && mdio_wr && mdio_reg == RA_ADV) |-> (mdio_wdata != adv_q));
   // R8
   ctl_wr_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_req && mdio_wr && mdio_reg == RA_CTL) |-> (mdio_wdata != ctl_q));
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> (!scan_done && !busy));
   // R3
   count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_count <= CNT_W'(SLOTS));
   // R9
   warn_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      no_phy_warn |-> (phy_count == '0));
endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
   import phy_scan_pkg::*;
#(
   parameter int SLOTS       = 4,
   parameter int WAIT_CYCLES = 500
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [15:0]                   force_adv,
   input  logic                          force_media,
   input  logic                          fdx_sel,
   input  logic                          spd100_sel,
   input  logic                          need_mii,
   output logic                          mdio_req,
   output logic                          mdio_wr,
   output logic [4:0]                    mdio_phy,
   output logic [4:0]                    mdio_reg,
   output logic [15:0]                   mdio_wdata,
   input  logic                          mdio_done,
   input  logic [15:0]                   mdio_rdata,
   output logic                          busy,
   output logic                          scan_done,
   output logic [$clog2(SLOTS+1)-1:0]    phy_count,
   output logic [SLOTS*5-1:0]            phy_addrs,
   output logic [SLOTS*16-1:0]           phy_advs,
   output logic                          no_phy_warn
);
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   logic              tbl_clr, tbl_addr_we, tbl_adv_we, tmr_go, tmr_run;
   logic [SLOT_W-1:0] tbl_idx;
   logic [ADDR_W-1:0] tbl_addr;
   logic [REG_W-1:0]  tbl_adv, tbl_adv_stored;

   phy_scan_fsm #(.SLOTS(SLOTS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start),
      .force_adv(force_adv), .force_media(force_media),
      .fdx_sel(fdx_sel), .spd100_sel(spd100_sel), .need_mii(need_mii),
      .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy(mdio_phy),
      .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
      .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
      .tbl_clr(tbl_clr), .tbl_addr_we(tbl_addr_we), .tbl_adv_we(tbl_adv_we),
      .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .tbl_adv(tbl_adv),
      .tbl_adv_stored(tbl_adv_stored),
      .tmr_go(tmr_go), .tmr_run(tmr_run),
      .busy(busy), .scan_done(scan_done), .phy_count(phy_count),
      .no_phy_warn(no_phy_warn)
   );

   phy_entry_table #(.SLOTS(SLOTS)) u_tbl (
      .clk(clk), .rst_n(rst_n), .clr(tbl_clr),
      .addr_we(tbl_addr_we), .adv_we(tbl_adv_we), .idx(tbl_idx),
      .addr_in(tbl_addr), .adv_in(tbl_adv), .adv_sel(tbl_adv_stored),
      .addr_flat(phy_addrs), .adv_flat(phy_advs)
   );

   phy_hold_timer #(.CYCLES(WAIT_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .go(tmr_go), .run(tmr_run)
   );
endmodule

// File: tb/sim_phy_scan_seq.sv
module sim_phy_scan_seq;
   localparam int WAIT = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] force_adv = '0;
   logic        force_media = 1'b0, fdx_sel = 1'b0, spd100_sel = 1'b0, need_mii = 1'b0;
   logic        mdio_req, mdio_wr, mdio_done, busy, scan_done, no_phy_warn;
   logic [4:0]  mdio_phy, mdio_reg;
   logic [15:0] mdio_wdata, mdio_rdata;
   logic [2:0]  phy_count;
   logic [19:0] phy_addrs;
   logic [63:0] phy_advs;

   int n_tests = 0, n_fail = 0;

   always #10 clk = ~clk;

   phy_scan_seq #(.SLOTS(4), .WAIT_CYCLES(WAIT)) u0 (.*);

   // management bus model with fixed register contents
   logic [15:0] m_stat [32];
   logic [15:0] m_ctl  [32];
   logic [15:0] m_adv  [32];
   logic        m_act = 1'b0, log_clr = 1'b0;
   logic [1:0]  m_cnt = '0;
   logic [4:0]  m_phy = '0, m_reg = '0;
   int cyc = 0, rcount = 0, wcount = 0;
   int rl_phy [64], rl_reg [64];
   int wl_phy [16], wl_reg [16], wl_dat [16], wl_cyc [16];

   function automatic logic [15:0] rd_val(input logic [4:0] p, input logic [4:0] r);
      case (r)
         5'd0:    return m_ctl[p];
         5'd1:    return m_stat[p];
         5'd4:    return m_adv[p];
         default: return 16'hFFFF;
      endcase
   endfunction

   initial mdio_done = 1'b0;
   initial mdio_rdata = '0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mdio_done <= 1'b0;
      if (log_clr) begin rcount <= 0; wcount <= 0; end
      if (!rst_n) begin
         m_act <= 1'b0; m_cnt <= '0;
      end else if (mdio_req) begin
         m_act <= 1'b1; m_cnt <= 2'd2; m_phy <= mdio_phy; m_reg <= mdio_reg;
         if (mdio_wr) begin
            if (wcount < 16) begin
               wl_phy[wcount] <= int'(mdio_phy); wl_reg[wcount] <= int'(mdio_reg);
               wl_dat[wcount] <= int'(mdio_wdata); wl_cyc[wcount] <= cyc;
            end
            wcount <= wcount + 1;
         end else begin
            if (rcount < 64) begin
               rl_phy[rcount] <= int'(mdio_phy); rl_reg[rcount] <= int'(mdio_reg);
            end
            rcount <= rcount + 1;
         end
      end else if (m_act) begin
         if (m_cnt == 2'd1) begin
            mdio_done <= 1'b1; m_act <= 1'b0; mdio_rdata <= rd_val(m_phy, m_reg);
         end
         m_cnt <= m_cnt - 2'd1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 32; i++) begin
         m_stat[i] = 16'hFFFF; m_ctl[i] = 16'hFFFF; m_adv[i] = 16'hFFFF;
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_scan(input logic [15:0] fa, input logic fm, input logic fd,
                           input logic sp, input logic nm);
      int t;
      @(negedge clk);
      force_adv = fa; force_media = fm; fdx_sel = fd; spd100_sel = sp; need_mii = nm;
      log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      t = 0;
      while (!scan_done && t < 5000) begin @(negedge clk); t++; end
      chk("R10 scan completes", 32'(t < 5000), 32'd1);
      @(negedge clk);
      chk("R10 done is one pulse", 32'(scan_done), 32'd0);
      chk("R10 busy falls", 32'(busy), 32'd0);
   endtask

   function automatic logic [4:0] addr_at(input int k);
      return phy_addrs[k*5 +: 5];
   endfunction
   function automatic logic [15:0] adv_at(input int k);
      return phy_advs[k*16 +: 16];
   endfunction

   task automatic t_reset();
      chk("R12 busy", 32'(busy), 0);
      chk("R12 done", 32'(scan_done), 0);
      chk("R12 req", 32'(mdio_req), 0);
      chk("R12 warn", 32'(no_phy_warn), 0);
      chk("R12 count", 32'(phy_count), 0);
      chk("R12 addrs", 32'(phy_addrs), 0);
      chk("R12 advs", 32'(phy_advs != '0), 0);
   endtask

   task automatic t_empty();
      model_clear();
      run_scan(16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R1 status reads", 32'(rcount), 32);
      chk("R1 first addr", 32'(rl_phy[0]), 1);
      chk("R1 second addr", 32'(rl_phy[1]), 2);
      chk("R1 last addr", 32'(rl_phy[31]), 0);
      chk("R1 status reg", 32'(rl_reg[31]), 1);
      chk("R2 all-ones rejected", 32'(phy_count), 0);
      chk("R2 no writes", 32'(wcount), 0);
      chk("R9 no warn without need", 32'(no_phy_warn), 0);
   endtask

   task automatic t_need_mii();
      model_clear();
      run_scan(16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R9 warn", 32'(no_phy_warn), 1);
      chk("R9 entry0 addr 1", 32'(addr_at(0)), 1);
      chk("R9 count stays 0", 32'(phy_count), 0);
   endtask

   task automatic t_mixed();
      model_clear();
      m_stat[3] = 16'h7849; m_ctl[3] = 16'h1000; m_adv[3] = 16'h01E1;
      m_stat[5] = 16'h8101;
      m_stat[6] = 16'h0001;
      m_stat[0] = 16'h8001; m_ctl[0] = 16'h0000; m_adv[0] = 16'h0000;
      run_scan(16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R9 warn cleared by start", 32'(no_phy_warn), 0);
      chk("R2 count", 32'(phy_count), 2);
      chk("R3 entry0", 32'(addr_at(0)), 3);
      chk("R3 entry1", 32'(addr_at(1)), 0);
      chk("R4 reads", 32'(rcount), 37);
      chk("R4 ctl read", 32'(rl_reg[3]), 0);
      chk("R4 adv read", 32'(rl_reg[4]), 4);
      chk("R4 next probe", 32'(rl_phy[5]), 4);
      chk("R4 cap reread reg", 32'(rl_reg[36]), 1);
      chk("R4 cap reread phy", 32'(rl_phy[36]), 0);
      chk("R6 R8 write count", 32'(wcount), 4);
      chk("R7 phy3 ctl", 32'(wl_dat[0]), 32'h1100);
      chk("R7 phy3 ctl reg", 32'(wl_reg[0]), 0);
      chk("R5 learned adv wins", 32'(wl_dat[1]), 32'h01E1);
      chk("R6 adv write reg", 32'(wl_reg[1]), 4);
      chk("R7 phy0 ctl first", 32'(wl_dat[2]), 32'h1300);
      chk("R8 phy0 ctl second", 32'(wl_dat[3]), 32'h1300);
      chk("R8 second to phy0", 32'(wl_phy[3]), 0);
      chk("R8 gap min", 32'(wl_cyc[3] - wl_cyc[2] >= WAIT), 1);
      chk("R8 gap max", 32'(wl_cyc[3] - wl_cyc[2] <= WAIT + 8), 1);
      chk("R5 entry0 adv", 32'(adv_at(0)), 32'h01E1);
      chk("R5 entry1 adv", 32'(adv_at(1)), 32'h01E1);
      repeat (10) @(negedge clk);
      chk("R10 count holds", 32'(phy_count), 2);
   endtask

   task automatic t_forced();
      model_clear();
      m_stat[2] = 16'h7809; m_ctl[2] = 16'h3100; m_adv[2] = 16'h01E1;
      run_scan(16'h0061, 1'b1, 1'b0, 1'b1, 1'b0);
      chk("R3 count", 32'(phy_count), 1);
      chk("R3 entry0", 32'(addr_at(0)), 2);
      chk("R3 entry1 cleared", 32'(addr_at(1)), 0);
      chk("R5 old entry1 adv kept", 32'(adv_at(1)), 32'h01E1);
      chk("R5 forced adv stored", 32'(adv_at(0)), 32'h0061);
      chk("R6 writes", 32'(wcount), 3);
      chk("R5 forced adv written", 32'(wl_dat[0]), 32'h0061);
      chk("R7 forced ctl", 32'(wl_dat[1]), 32'h2000);
      chk("R8 forced ctl twice", 32'(wl_dat[2]), 32'h2000);
   endtask

   task automatic t_stored();
      do_reset();
      model_clear();
      m_stat[7] = 16'h7809; m_ctl[7] = 16'h1100; m_adv[7] = 16'h01E1;
      run_scan(16'h0041, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R8 unchanged ctl not written", 32'(wcount), 1);
      chk("R6 forced adv", 32'(wl_dat[0]), 32'h0041);
      run_scan(16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R5 stored entry used", 32'(wl_dat[0]), 32'h0041);
      chk("R5 stored single write", 32'(wcount), 1);
      chk("R5 entry0 adv", 32'(adv_at(0)), 32'h0041);
   endtask

   task automatic t_full();
      model_clear();
      foreach (m_stat[i]) begin
         if (i == 1 || i == 2 || i == 4 || i == 8 || i == 9 || i == 10) begin
            m_stat[i] = 16'h7809; m_ctl[i] = 16'h1100; m_adv[i] = 16'h01E1;
         end
      end
      run_scan(16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R3 full count", 32'(phy_count), 4);
      chk("R3 entry0", 32'(addr_at(0)), 1);
      chk("R3 entry1", 32'(addr_at(1)), 2);
      chk("R3 entry2", 32'(addr_at(2)), 4);
      chk("R3 entry3", 32'(addr_at(3)), 8);
      chk("R3 reads stop", 32'(rcount), 16);
      chk("R3 last read phy", 32'(rl_phy[15]), 8);
      chk("R5 writes", 32'(wcount), 1);
      chk("R5 stored slot0", 32'(wl_dat[0]), 32'h0041);
      chk("R5 adv slot1", 32'(adv_at(1)), 32'h01E1);
      chk("R5 adv slot3", 32'(adv_at(3)), 32'h01E1);
   endtask

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_empty();
      t_need_mii();
      t_mixed();
      t_forced();
      t_stored();
      t_full();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule